// File: doc/BRIEF.md
# Embedded Controller Host Port

This block is the device side of a byte-wide mailbox. Through it a host reaches an internal register space with 8-bit addresses, one byte per transfer. The host sees two locations. The data location carries address bytes, write data and read results. The control location returns a status byte when it is read and takes a command byte when it is written. Two status flags pace the exchange:

- **Input-full** stays set while the device is still consuming a byte the host wrote.
- **Output-full** is set while a result waits at the data location for the host to collect it.

There are two commands. A fetch command takes one address byte, reads that register and leaves its value for the host. A store command takes an address byte and then a data byte, and writes the data to that register.

On the back side the block issues single-beat register requests over a valid/ready handshake. Back-pressure rule: once `req_valid` is raised, it and the request payload hold steady until `req_ready` is seen high at a clock edge. A read result is taken from `rsp_rdata` on the cycle after its request was accepted, so the register space must answer with a fixed one-cycle latency. Host access is plain strobes; a host that keeps to the flags never needs a stall.

Top module: `ec_host_port`

## Requirements
- R1: After reset both flags are clear, a status read returns 0x00, and no back-side request is raised.
- R2: A host write to the data location (offset 0) or the control location (offset 4), made while input-full is clear, sets input-full on the following cycle. Status reads return input-full in bit 1, output-full in bit 0 and zeros in bits 7:2. When no back-side request is pending, input-full stays set for exactly CONSUME_CYC cycles.
- R3: A host write made while input-full is set is dropped and has no effect on the sequence.
- R4: Writing command 0x80 and then one address byte issues exactly one read request (`req_we`=0) to that address. The value returned is then presented at the data location and output-full is set.
- R5: A host read strobe on the data location clears output-full.
- R6: Writing command 0x81, then an address byte, then a data byte issues exactly one write request (`req_we`=1) carrying that address and that data.
- R7: While a back-side request waits for `req_ready`, input-full remains set, and `req_valid`, `req_we`, `req_addr` and `req_wdata` do not change.
- R8: A command byte other than 0x80 or 0x81 returns the sequencer to idle. Data bytes written while idle issue no request.
- R9: A valid command written partway through a sequence abandons that sequence and starts the new one.
- R10: Any accepted command write clears output-full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | HOST_AW | Host location select (data at 0, control at 4) |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe; on the data location it collects the result |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Status byte or result byte, selected by host_addr |
| req_valid | output | 1 | Back-side request valid |
| req_ready | input | 1 | Back-side request accepted |
| req_we | output | 1 | 1 for a register write, 0 for a register read |
| req_addr | output | REG_AW | Register address |
| req_wdata | output | 8 | Register write data |
| rsp_rdata | input | 8 | Read data, valid the cycle after an accepted read |

## Verification
The following are checked on every cycle by assertions:
- a request stalled by `req_ready` keeps its payload and keeps input-full set;
- an accepted host write raises input-full;
- a command write drops output-full;
- output-full only ever rises two cycles after an accepted read request;
- the unused status bits stay zero.

Some behaviours are properties of whole byte sequences, and only the bench's scenarios can show them: which address and data actually reach the register space, that unknown commands and stray idle bytes produce no request, that a mid-sequence command redirects the transfer, that dropped writes leave no trace, and the exact length of the input-full window.

// File: rtl/ec_mbox_pkg.sv
package ec_mbox_pkg;
  localparam logic [7:0] CMD_FETCH = 8'h80;
  localparam logic [7:0] CMD_STORE = 8'h81;
  localparam int STS_OUT_BIT = 0;
  localparam int STS_IN_BIT  = 1;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FADDR,   // fetch: waiting for address byte
    S_SADDR,   // store: waiting for address byte
    S_SDATA,   // store: waiting for data byte
    S_FREQ,    // fetch request on back side
    S_FRSP,    // capture fetch result
    S_SREQ     // store request on back side
  } seq_state_e;
endpackage

// File: rtl/ec_mbox_flags.sv
module ec_mbox_flags #(
  parameter int CONSUME_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       latch_i,
  input  logic       busy_i,
  input  logic       out_set_i,
  input  logic [7:0] out_byte_i,
  input  logic       out_take_i,
  input  logic       out_kill_i,
  output logic       in_full_o,
  output logic       out_full_o,
  output logic [7:0] out_byte_o
);
  localparam int CW = $clog2(CONSUME_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(CONSUME_CYC - 1);

  logic [CW-1:0] cnt_q;

  // input-full window: load on latch, count down, release once idle behind it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_full_o <= 1'b0;
      cnt_q     <= '0;
    end else if (latch_i) begin
      in_full_o <= 1'b1;
      cnt_q     <= LOAD;
    end else if (in_full_o) begin
      if (cnt_q != '0)  cnt_q     <= cnt_q - 1'b1;
      else if (!busy_i) in_full_o <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_full_o <= 1'b0;
      out_byte_o <= '0;
    end else if (out_set_i) begin
      out_full_o <= 1'b1;
      out_byte_o <= out_byte_i;
    end else if (out_take_i || out_kill_i) begin
      out_full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ec_mbox_seq.sv
module ec_mbox_seq
  import ec_mbox_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr_i,
  input  logic              dat_wr_i,
  input  logic [7:0]        byte_i,
  input  logic              req_ready_i,
  input  logic [7:0]        rsp_rdata_i,
  output logic              req_valid_o,
  output logic              req_we_o,
  output logic [REG_AW-1:0] req_addr_o,
  output logic [7:0]        req_wdata_o,
  output logic              busy_o,
  output logic              out_set_o,
  output logic [7:0]        out_byte_o
);
  seq_state_e        state_q;
  logic [REG_AW-1:0] addr_q;
  logic [7:0]        data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (cmd_wr_i) begin
      case (byte_i)
        CMD_FETCH: state_q <= S_FADDR;
        CMD_STORE: state_q <= S_SADDR;
        default:   state_q <= S_IDLE;
      endcase
    end else begin
      case (state_q)
        S_FADDR: if (dat_wr_i) begin
          addr_q  <= byte_i[REG_AW-1:0];
          state_q <= S_FREQ;
        end
        S_SADDR: if (dat_wr_i) begin
          addr_q  <= byte_i[REG_AW-1:0];
          state_q <= S_SDATA;
        end
        S_SDATA: if (dat_wr_i) begin
          data_q  <= byte_i;
          state_q <= S_SREQ;
        end
        S_FREQ:  if (req_ready_i) state_q <= S_FRSP;
        S_FRSP:  state_q <= S_IDLE;
        S_SREQ:  if (req_ready_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_valid_o = (state_q == S_FREQ) || (state_q == S_SREQ);
  assign req_we_o    = (state_q == S_SREQ);
  assign req_addr_o  = addr_q;
  assign req_wdata_o = data_q;
  assign busy_o      = req_valid_o || (state_q == S_FRSP);
  assign out_set_o   = (state_q == S_FRSP);
  assign out_byte_o  = rsp_rdata_i;
endmodule

// File: rtl/ec_host_port.sv
module ec_host_port
  import ec_mbox_pkg::*;
#(
  parameter int HOST_AW     = 3,
  parameter int DATA_OFS    = 0,
  parameter int CMD_OFS     = 4,
  parameter int CONSUME_CYC = 4,
  parameter int REG_AW      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_we,
  output logic [REG_AW-1:0] req_addr,
  output logic [7:0]        req_wdata,
  input  logic [7:0]        rsp_rdata
);
  localparam logic [HOST_AW-1:0] DATA_SEL = HOST_AW'(DATA_OFS);
  localparam logic [HOST_AW-1:0] CMD_SEL  = HOST_AW'(CMD_OFS);

  logic ibf, obf, busy, out_set;
  logic [7:0] out_byte_in, out_byte;
  logic hit_data, hit_cmd, accept, cmd_wr, dat_wr;

  assign hit_data = (host_addr == DATA_SEL);
  assign hit_cmd  = (host_addr == CMD_SEL);
  assign accept   = host_wr && !ibf;
  assign cmd_wr   = accept && hit_cmd;
  assign dat_wr   = accept && hit_data;

  ec_mbox_seq #(.REG_AW(REG_AW)) i_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr_i(cmd_wr), .dat_wr_i(dat_wr), .byte_i(host_wdata),
    .req_ready_i(req_ready), .rsp_rdata_i(rsp_rdata),
    .req_valid_o(req_valid), .req_we_o(req_we), .req_addr_o(req_addr),
    .req_wdata_o(req_wdata), .busy_o(busy),
    .out_set_o(out_set), .out_byte_o(out_byte_in)
  );

  ec_mbox_flags #(.CONSUME_CYC(CONSUME_CYC)) i_flags (
    .clk(clk), .rst_n(rst_n),
    .latch_i(cmd_wr || dat_wr), .busy_i(busy),
    .out_set_i(out_set), .out_byte_i(out_byte_in),
    .out_take_i(host_rd && hit_data), .out_kill_i(cmd_wr),
    .in_full_o(ibf), .out_full_o(obf), .out_byte_o(out_byte)
  );

  always_comb begin
    host_rdata = '0;
    if (hit_cmd) begin
      host_rdata[STS_IN_BIT]  = ibf;
      host_rdata[STS_OUT_BIT] = obf;
    end else if (hit_data) begin
      host_rdata = out_byte;
    end
  end
endmodule

// File: rtl/ec_host_port_chk.sv
module ec_host_port_chk #(
  parameter int HOST_AW  = 3,
  parameter int DATA_OFS = 0,
  parameter int CMD_OFS  = 4,
  parameter int REG_AW   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [HOST_AW-1:0] host_addr,
  input logic               host_wr,
  input logic [7:0]         host_rdata,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_we,
  input logic [REG_AW-1:0]  req_addr,
  input logic [7:0]         req_wdata,
  input logic               ibf,
  input logic               obf
);
  localparam logic [HOST_AW-1:0] DSEL = HOST_AW'(DATA_OFS);
  localparam logic [HOST_AW-1:0] CSEL = HOST_AW'(CMD_OFS);

  p_ibf_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !ibf && (host_addr == DSEL || host_addr == CSEL)) |=> ibf);

  p_status_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == CSEL) |-> (host_rdata[7:2] == 6'd0));

  p_obf_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(obf) |-> $past(req_valid && req_ready && !req_we, 2));

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_we) &&
                                   $stable(req_addr) && $stable(req_wdata)));

  p_busy_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ibf);

  p_cmd_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !ibf && host_addr == CSEL) |=> !obf);
endmodule

bind ec_host_port ec_host_port_chk #(
  .HOST_AW(HOST_AW), .DATA_OFS(DATA_OFS), .CMD_OFS(CMD_OFS), .REG_AW(REG_AW)
) i_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
  .host_rdata(host_rdata), .req_valid(req_valid), .req_ready(req_ready),
  .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
  .ibf(ibf), .obf(obf)
);

// File: tb/test_ec_host_port.sv
module test_ec_host_port;
  localparam int CLK_PERIOD = 10;
  localparam int CC = 4;
  localparam logic [2:0] DP = 3'd0;
  localparam logic [2:0] CP = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] host_addr = '0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic req_valid, req_we, req_ready = 1'b1;
  logic [7:0] req_addr, req_wdata, rsp_rdata = '0;

  int checks = 0, errors = 0;
  int rd_reqs = 0, wr_reqs = 0;
  logic [7:0] last_addr = '0, last_wdata = '0;
  logic [7:0] mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  ec_host_port #(.CONSUME_CYC(CC)) i_ec_host_port (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata)
  );

  // register-space model: one-cycle read latency
  always @(posedge clk) begin
    if (req_valid && req_ready) begin
      last_addr <= req_addr;
      if (req_we) begin
        mem[req_addr] <= req_wdata;
        last_wdata    <= req_wdata;
        wr_reqs       <= wr_reqs + 1;
      end else begin
        rsp_rdata <= mem[req_addr];
        rd_reqs   <= rd_reqs + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic status(output logic [7:0] s);
    host_addr = CP; #1; s = host_rdata;
  endtask

  task automatic wait_ibf_clear();
    logic [7:0] s;
    for (int i = 0; i < 200; i++) begin
      status(s);
      if (!s[1]) return;
      @(negedge clk);
    end
  endtask

  task automatic take_data(output logic [7:0] v);
    @(negedge clk);
    host_addr = DP; host_rd = 1'b1; #1; v = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic do_fetch(input logic [7:0] a, output logic [7:0] v);
    hwrite(CP, 8'h80); wait_ibf_clear();
    hwrite(DP, a);     wait_ibf_clear();
    take_data(v);
  endtask

  task automatic t_reset();
    logic [7:0] s;
    status(s);
    chk("R1 status", s, 8'h00);
    chk("R1 req_valid", req_valid, 1'b0);
  endtask

  task automatic t_ibf_window();
    logic [7:0] s;
    int n0;
    n0 = rd_reqs + wr_reqs;
    hwrite(DP, 8'h33);               // idle data byte
    status(s); chk("R2 ibf set", s, 8'h02);
    repeat (CC - 1) @(negedge clk);
    status(s); chk("R2 ibf last cycle", s[1], 1'b1);
    @(negedge clk);
    status(s); chk("R2 ibf clear", s[1], 1'b0);
    chk("R8 idle byte no request", rd_reqs + wr_reqs, n0);
  endtask

  task automatic t_fetch();
    logic [7:0] s, v;
    int n0;
    n0 = rd_reqs;
    hwrite(CP, 8'h80); wait_ibf_clear();
    hwrite(DP, 8'h21); wait_ibf_clear();
    status(s); chk("R4 obf set", s[0], 1'b1);
    chk("R4 one read", rd_reqs, n0 + 1);
    chk("R4 read addr", last_addr, 8'h21);
    take_data(v);
    chk("R4 result", v, 8'h21 ^ 8'h5A);
    status(s); chk("R5 obf cleared", s[0], 1'b0);
  endtask

  task automatic t_store();
    logic [7:0] v;
    int n0;
    n0 = wr_reqs;
    hwrite(CP, 8'h81); wait_ibf_clear();
    hwrite(DP, 8'h40); wait_ibf_clear();
    hwrite(DP, 8'hC3); wait_ibf_clear();
    chk("R6 one write", wr_reqs, n0 + 1);
    chk("R6 write addr", last_addr, 8'h40);
    chk("R6 write data", last_wdata, 8'hC3);
    do_fetch(8'h40, v);
    chk("R6 readback", v, 8'hC3);
  endtask

  task automatic t_backpressure();
    logic [7:0] s;
    int n0;
    n0 = wr_reqs;
    req_ready = 1'b0;
    hwrite(CP, 8'h81); wait_ibf_clear();
    hwrite(DP, 8'h10); wait_ibf_clear();
    hwrite(DP, 8'h99);
    repeat (10) @(negedge clk);
    status(s); chk("R7 ibf held", s[1], 1'b1);
    chk("R7 valid held", req_valid, 1'b1);
    chk("R7 addr held", req_addr, 8'h10);
    chk("R7 data held", req_wdata, 8'h99);
    req_ready = 1'b1;
    wait_ibf_clear();
    chk("R7 write after release", wr_reqs, n0 + 1);
  endtask

  task automatic t_drop_when_full();
    logic [7:0] v;
    int n0;
    n0 = rd_reqs;
    hwrite(CP, 8'h80);
    hwrite(DP, 8'h05);               // ibf still set: dropped
    wait_ibf_clear();
    hwrite(DP, 8'h06); wait_ibf_clear();
    chk("R3 single read", rd_reqs, n0 + 1);
    chk("R3 addr from later byte", last_addr, 8'h06);
    take_data(v);
    chk("R3 result", v, 8'h06 ^ 8'h5A);
  endtask

  task automatic t_unknown();
    int n0;
    n0 = rd_reqs + wr_reqs;
    hwrite(CP, 8'h81); wait_ibf_clear();
    hwrite(DP, 8'h50); wait_ibf_clear();
    hwrite(CP, 8'h7E); wait_ibf_clear();
    hwrite(DP, 8'h11); wait_ibf_clear();
    hwrite(DP, 8'h12); wait_ibf_clear();
    chk("R8 unknown command no request", rd_reqs + wr_reqs, n0);
  endtask

  task automatic t_abort();
    logic [7:0] v;
    int w0, r0;
    w0 = wr_reqs; r0 = rd_reqs;
    hwrite(CP, 8'h81); wait_ibf_clear();
    hwrite(DP, 8'h60); wait_ibf_clear();
    hwrite(CP, 8'h80); wait_ibf_clear();
    hwrite(DP, 8'h61); wait_ibf_clear();
    chk("R9 no write", wr_reqs, w0);
    chk("R9 read issued", rd_reqs, r0 + 1);
    take_data(v);
    chk("R9 result", v, 8'h61 ^ 8'h5A);
  endtask

  task automatic t_cmd_clears();
    logic [7:0] s;
    hwrite(CP, 8'h80); wait_ibf_clear();
    hwrite(DP, 8'h02); wait_ibf_clear();
    status(s); chk("R10 obf before", s[0], 1'b1);
    hwrite(CP, 8'h81);
    status(s); chk("R10 obf dropped", s[0], 1'b0);
    wait_ibf_clear();
    hwrite(CP, 8'h00); wait_ibf_clear();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ibf_window();
    t_fetch();
    t_store();
    t_backpressure();
    t_drop_when_full();
    t_unknown();
    t_abort();
    t_cmd_clears();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule